// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block issues serial flash commands on one chip select, in SPI mode 0, on behalf of software that programs it through a small register bus. Software does not send raw command bytes. It first fills an eight-slot opcode menu, a two-slot prefix table and a 16-bit type table. Each menu slot has a two-bit type that decides whether a 24-bit address follows the opcode and whether the command writes or reads data. Software then sets the address and fills a 64-byte data buffer. A single write to the control register picks a menu slot and starts the cycle.

A cycle can start with an atomic prefix command, such as a write enable. The prefix goes out in its own chip-select frame. Chip select then rises for a guaranteed gap, and the main frame follows. The main frame holds the opcode, an optional address and 1 to 64 data bytes. Data bytes either come from the buffer or are captured into it. An external protection check drives `access_blocked`. When that input is high at the moment a cycle starts, the block drops the cycle and raises a flag. Once software sets the lock bit, the opcode tables can no longer be changed.

Register word addresses on `bus_addr` are: 0 status, 1 control, 2 address bits 15:0, 3 address bits 23:16, 4 type table, 5 prefix table (slot 0 in bits 7:0, slot 1 in bits 15:8), 6 to 9 opcode menu (two slots per word, the even slot in the low byte: word 6 holds slots 0 and 1), and 64 to 127 the data buffer bytes 0 to 63 (in bits 7:0).

Top module: `spi_seq`

## Requirements
- R1: After reset, the status, control and address registers and the type, prefix and menu tables all read 0. `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: The control word has these fields: bit 14 data-present, bits 13:8 byte count minus one, bits 6:4 menu slot, bit 3 prefix slot, bit 2 atomic, bit 1 go. Bits 15 and 0 are stored without effect. Writing go=1 while idle starts a cycle. Status bit 0 (in progress) reads 1 from the next clock until the cycle ends. Go always reads back 0.
- R3: The main frame starts with the selected menu opcode, MSB first. The bus is SPI mode 0: SCLK idles low, MOSI changes after a falling edge and MISO is sampled on the rising edge. One SCLK period is CLK_DIV clocks. Chip select is low only while a frame is being sent.
- R4: When bit 1 of the slot's type pair (type bit 2*slot+1) is set, address bits 23:16, 15:8 and 7:0 follow the opcode, in that order.
- R5: With data-present set, exactly count+1 data bytes follow the opcode or the address. With data-present clear, no data bytes follow.
- R6: When bit 0 of the slot's type pair (type bit 2*slot) is set, the command is write-type: the data bytes are buffer bytes 0, 1, 2 and so on.
- R7: When that bit is clear, the command is read-type: MOSI holds 0 during the data bytes, and the received bytes are stored in buffer bytes 0 upward.
- R8: With atomic set, the selected prefix byte is sent alone in a first frame. Chip select then stays high for at least GAP_SCLK*CLK_DIV clocks before the main frame. Status bit 0 stays 1 across both frames.
- R9: Status bit 2 (done) rises on the same clock on which bit 0 falls. Writing 1 to status bit 2 clears it.
- R10: If `access_blocked` is 1 when go is accepted, chip select never falls. Status bit 3 (blocked) sets, and neither bit 2 nor bit 0 sets. Writing 1 to status bit 3 clears it.
- R11: Writes to the control and address registers during a cycle are ignored, including a second go.
- R12: Status bit 15 (lock) is set by writing 1 and cannot be cleared except by reset. While it is set, writes to the type, prefix and menu tables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| access_blocked | input | 1 | Protection check result for the pending cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV=4 and GAP_SCLK=2. At these values every SCLK half period spans two system clocks, so the bus-side model sees clean, separate edges. The inter-frame gap must then be at least 8 clocks, which the bench measures directly. A full 64-byte program with prefix, address and maximum count also stays short enough to run next to the read, erase, blocked, busy-write and lock scenarios.

// File: rtl/spi_seq.sv
module spi_seq #(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [6:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        access_blocked,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GAPC = GAP_SCLK * CLK_DIV;
  localparam int GW   = (GAPC > 1) ? $clog2(GAPC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} st_t;
  st_t st;

  logic [15:0] ctl_q, type_q, pre_q;
  logic [63:0] menu_q;
  logic [23:0] addr_q;
  logic        lock_q, done_q, blk_q;
  logic [7:0]  buf_q [64];

  logic [DIVW-1:0] div_cnt;
  logic [GW-1:0]   gap_cnt;
  logic [2:0]      bit_cnt;
  logic [6:0]      byte_idx;
  logic [7:0]      tx_sh, rx_sh;
  logic            sclk_q, cs_q;

  wire busy   = (st != S_IDLE);
  wire wr_sts = bus_wr && (bus_addr == 7'd0);
  wire wr_ctl = bus_wr && (bus_addr == 7'd1) && !busy;
  wire go_acc = wr_ctl && bus_wdata[1];

  wire [15:0] ctl_eff  = go_acc ? bus_wdata : ctl_q;
  wire        dp       = ctl_eff[14];
  wire [5:0]  cnt      = ctl_eff[13:8];
  wire [2:0]  opi      = ctl_eff[6:4];
  wire        pfi      = ctl_eff[3];
  wire        atom     = ctl_eff[2];
  wire [1:0]  typ      = type_q[{opi, 1'b0} +: 2];
  wire        has_addr = typ[1];
  wire        is_wr    = typ[0];
  wire [7:0]  opcode   = menu_q[{opi, 3'b000} +: 8];
  wire [7:0]  pfx      = pre_q[{pfi, 3'b000} +: 8];
  wire [6:0]  d_off    = has_addr ? 7'd4 : 7'd1;
  wire [6:0]  nbytes   = 7'd1 + (has_addr ? 7'd3 : 7'd0) + (dp ? ({1'b0, cnt} + 7'd1) : 7'd0);

  wire tick     = (div_cnt == DIVW'(HALF - 1));
  wire byte_end = tick && sclk_q && (bit_cnt == 3'd7);
  wire last     = (byte_idx == nbytes - 7'd1);
  wire fin      = (st == S_MAIN) && byte_end && last;
  wire [6:0] cap_idx = byte_idx - d_off;
  wire cap      = (st == S_MAIN) && byte_end && dp && !is_wr && (byte_idx >= d_off);

  logic [6:0] nk, ndk;
  logic [7:0] nxt_byte;
  always_comb begin
    nk  = byte_idx + 7'd1;
    ndk = nk - d_off;
    if (has_addr && nk < 7'd4)
      nxt_byte = (nk == 7'd1) ? addr_q[23:16] : (nk == 7'd2) ? addr_q[15:8] : addr_q[7:0];
    else if (is_wr)
      nxt_byte = buf_q[ndk[5:0]];
    else
      nxt_byte = 8'h00;
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = !cs_q && tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_q <= 1'b1; sclk_q <= 1'b0;
      div_cnt <= '0; gap_cnt <= '0; bit_cnt <= '0; byte_idx <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_acc && !access_blocked) begin
          cs_q <= 1'b0; sclk_q <= 1'b0; div_cnt <= '0; bit_cnt <= '0; byte_idx <= '0;
          st    <= atom ? S_PRE : S_MAIN;
          tx_sh <= atom ? pfx : opcode;
        end
        S_PRE, S_MAIN: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sh  <= {rx_sh[6:0], spi_miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_cnt == 3'd7) begin
                bit_cnt <= '0;
                if (st == S_PRE) begin
                  cs_q <= 1'b1; st <= S_GAP; gap_cnt <= '0;
                end else if (last) begin
                  cs_q <= 1'b1; st <= S_IDLE;
                end else begin
                  byte_idx <= nk; tx_sh <= nxt_byte;
                end
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
                tx_sh   <= {tx_sh[6:0], 1'b0};
              end
            end
          end
        end
        default: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GW'(GAPC - 1)) begin
            st <= S_MAIN; cs_q <= 1'b0; div_cnt <= '0; bit_cnt <= '0;
            byte_idx <= '0; tx_sh <= opcode;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; addr_q <= '0; type_q <= '0; pre_q <= '0; menu_q <= '0;
      lock_q <= 1'b0; done_q <= 1'b0; blk_q <= 1'b0;
    end else begin
      done_q <= fin | (done_q & ~(wr_sts & bus_wdata[2]));
      blk_q  <= (go_acc & access_blocked) | (blk_q & ~(wr_sts & bus_wdata[3]));
      lock_q <= lock_q | (wr_sts & bus_wdata[15]);
      if (wr_ctl) ctl_q <= bus_wdata & 16'hFFFD;
      if (bus_wr && !busy && bus_addr == 7'd2) addr_q[15:0]  <= bus_wdata;
      if (bus_wr && !busy && bus_addr == 7'd3) addr_q[23:16] <= bus_wdata[7:0];
      if (bus_wr && !lock_q) begin
        case (bus_addr)
          7'd4: type_q <= bus_wdata;
          7'd5: pre_q  <= bus_wdata;
          7'd6: menu_q[15:0]  <= bus_wdata;
          7'd7: menu_q[31:16] <= bus_wdata;
          7'd8: menu_q[47:32] <= bus_wdata;
          7'd9: menu_q[63:48] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) buf_q[i] <= '0;
    end else if (cap) begin
      buf_q[cap_idx[5:0]] <= rx_sh;
    end else if (bus_wr && bus_addr[6]) begin
      buf_q[bus_addr[5:0]] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    case (bus_addr)
      7'd0:    bus_rdata = {lock_q, 11'b0, blk_q, done_q, 1'b0, busy};
      7'd1:    bus_rdata = ctl_q;
      7'd2:    bus_rdata = addr_q[15:0];
      7'd3:    bus_rdata = {8'h00, addr_q[23:16]};
      7'd4:    bus_rdata = type_q;
      7'd5:    bus_rdata = pre_q;
      7'd6:    bus_rdata = menu_q[15:0];
      7'd7:    bus_rdata = menu_q[31:16];
      7'd8:    bus_rdata = menu_q[47:32];
      7'd9:    bus_rdata = menu_q[63:48];
      default: bus_rdata = bus_addr[6] ? {8'h00, buf_q[bus_addr[5:0]]} : 16'h0000;
    endcase
  end
endmodule

module chk_spi_seq (
  input logic        clk,
  input logic        rst_n,
  input logic        access_blocked,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        busy,
  input logic        go_acc,
  input logic        done_q,
  input logic        blk_q,
  input logic        lock_q,
  input logic [15:0] type_q,
  input logic [15:0] pre_q,
  input logic [63:0] menu_q
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_acc && !access_blocked) |=> busy);
  assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  assert_sclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_done_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_acc && access_blocked) |=> (blk_q && !busy && spi_cs_n));
  assert_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(type_q) && $stable(pre_q) && $stable(menu_q)));
endmodule

bind spi_seq chk_spi_seq i_chk (.*);

// File: tb/test_spi_seq.sv
module test_spi_seq;
  localparam int CLK_DIV  = 4;
  localparam int GAP_SCLK = 2;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, access_blocked = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  spi_seq #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) i_spi_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int frames = 0, bitn = 0, nlog = 0, hi_cnt = 0, last_gap = 0;
  logic [7:0] sh;
  logic [7:0] log_b [0:255];
  int         log_f [0:255];

  function automatic logic [7:0] pat(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  assign spi_miso = pat(bitn / 8)[7 - (bitn % 8)];

  always @(negedge spi_cs_n) begin frames++; bitn = 0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitn++;
    if (bitn % 8 == 0) begin log_b[nlog] = sh; log_f[nlog] = frames; nlog++; end
  end
  always @(negedge clk) begin
    if (spi_cs_n) hi_cnt++;
    else begin if (hi_cnt > 0) last_gap = hi_cnt; hi_cnt = 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [15:0] ctlv(input bit dp, input int cnt, input int idx, input bit pi, input bit atom);
    return (16'(dp) << 14) | (16'(cnt) << 8) | (16'(idx) << 4) | (16'(pi) << 3) | (16'(atom) << 2) | 16'h0003;
  endfunction

  task automatic wait_idle(input string req);
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(7'd0, s);
      if (!s[0]) return;
    end
    check({req, " timeout"}, 1, 0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 10; a++) begin rd(7'(a), d); check("R1 reg", d, 0); end
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sclk", spi_sclk, 0);
  endtask

  task automatic t_config();
    wr(7'd6, 16'h0B03); wr(7'd7, 16'h9F05); wr(7'd8, 16'h2002); wr(7'd9, 16'h01D8);
    wr(7'd5, 16'h0650); wr(7'd4, 16'h7F0A);
  endtask

  task automatic t_read_status();
    logic [15:0] d; int f0;
    nlog = 0; f0 = frames;
    wr(7'd1, ctlv(1, 0, 2, 0, 0));
    rd(7'd0, d); check("R2 busy during cycle", d[0], 1);
    rd(7'd1, d); check("R2 go reads 0", d, ctlv(1, 0, 2, 0, 0) & 16'hFFFD);
    wait_idle("R3");
    check("R3 byte count", nlog, 2);
    check("R3 opcode", log_b[0], 8'h05);
    check("R7 mosi zero", log_b[1], 8'h00);
    check("R3 one frame", frames, f0 + 1);
    rd(7'd64, d); check("R7 captured byte", d, {8'h00, pat(1)});
    rd(7'd0, d); check("R9 done set", d, 16'h0004);
    wr(7'd0, 16'h0004);
    rd(7'd0, d); check("R9 done cleared", d, 16'h0000);
  endtask

  task automatic t_read_addr();
    logic [15:0] d;
    nlog = 0;
    wr(7'd2, 16'h3456); wr(7'd3, 16'h0012);
    wr(7'd1, ctlv(1, 3, 0, 0, 0));
    wait_idle("R4");
    check("R5 byte count", nlog, 8);
    check("R3 opcode", log_b[0], 8'h03);
    check("R4 addr hi", log_b[1], 8'h12);
    check("R4 addr mid", log_b[2], 8'h34);
    check("R4 addr lo", log_b[3], 8'h56);
    for (int i = 0; i < 4; i++) begin
      rd(7'(64 + i), d); check("R7 buffer fill", d, {8'h00, pat(4 + i)});
    end
    wr(7'd0, 16'h0004);
  endtask

  task automatic t_no_data();
    nlog = 0;
    wr(7'd1, ctlv(0, 5, 3, 0, 0));
    wait_idle("R5");
    check("R5 no data bytes", nlog, 1);
    check("R5 opcode only", log_b[0], 8'h9F);
    wr(7'd0, 16'h0004);
  endtask

  task automatic t_program();
    logic [15:0] d; int f0; bit ok;
    for (int i = 0; i < 64; i++) wr(7'(64 + i), 16'(i * 3 + 1));
    wr(7'd2, 16'hCDEF); wr(7'd3, 16'h00AB);
    nlog = 0; f0 = frames;
    wr(7'd1, ctlv(1, 63, 4, 1, 1));
    wait_idle("R8");
    check("R8 total bytes", nlog, 69);
    check("R8 prefix byte", log_b[0], 8'h06);
    check("R8 prefix own frame", log_f[0], f0 + 1);
    check("R8 main frame", log_f[1], f0 + 2);
    check("R8 gap length", last_gap >= GAP_SCLK * CLK_DIV, 1);
    check("R3 opcode", log_b[1], 8'h02);
    check("R4 addr", {log_b[2], log_b[3], log_b[4]}, 24'hABCDEF);
    ok = 1;
    for (int i = 0; i < 64; i++) if (log_b[5 + i] !== 8'(i * 3 + 1)) ok = 0;
    check("R6 buffer sent in order", ok, 1);
    rd(7'd0, d); check("R9 done after atomic", d, 16'h0004);
    wr(7'd0, 16'h0004);
  endtask

  task automatic t_erase();
    int f0;
    nlog = 0; f0 = frames;
    wr(7'd1, ctlv(0, 0, 5, 0, 1));
    wait_idle("R8");
    check("R8 two frames", frames, f0 + 2);
    check("R8 prefix slot 0", log_b[0], 8'h50);
    check("R4 erase bytes", {log_b[1], log_b[2], log_b[3], log_b[4]}, 32'h20ABCDEF);
    check("R5 erase count", nlog, 5);
    wr(7'd0, 16'h0004);
  endtask

  task automatic t_busy_write();
    logic [15:0] d; int f0;
    nlog = 0; f0 = frames;
    wr(7'd1, ctlv(1, 0, 2, 0, 0));
    wr(7'd1, ctlv(0, 0, 3, 0, 0));
    wr(7'd2, 16'h1111);
    wait_idle("R11");
    check("R11 one frame", frames, f0 + 1);
    check("R11 first opcode kept", log_b[0], 8'h05);
    rd(7'd1, d); check("R11 control kept", d, ctlv(1, 0, 2, 0, 0) & 16'hFFFD);
    rd(7'd2, d); check("R11 address kept", d, 16'hCDEF);
    wr(7'd0, 16'h0004);
  endtask

  task automatic t_blocked();
    logic [15:0] d; int f0;
    f0 = frames;
    @(negedge clk); access_blocked = 1'b1;
    wr(7'd1, ctlv(1, 0, 0, 0, 0));
    access_blocked = 1'b0;
    repeat (40) @(negedge clk);
    rd(7'd0, d); check("R10 blocked flag only", d, 16'h0008);
    check("R10 no frame", frames, f0);
    wr(7'd0, 16'h0008);
    rd(7'd0, d); check("R10 blocked cleared", d, 16'h0000);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr(7'd0, 16'h8000);
    rd(7'd0, d); check("R12 lock set", d, 16'h8000);
    wr(7'd6, 16'hFFFF); wr(7'd4, 16'h0000); wr(7'd5, 16'h1234);
    rd(7'd6, d); check("R12 menu kept", d, 16'h0B03);
    rd(7'd4, d); check("R12 type kept", d, 16'h7F0A);
    rd(7'd5, d); check("R12 prefix kept", d, 16'h0650);
    wr(7'd0, 16'h0000);
    rd(7'd0, d); check("R12 lock sticky", d, 16'h8000);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_read_status();
    t_read_addr();
    t_no_data();
    t_program();
    t_erase();
    t_busy_write();
    t_blocked();
    t_lock();
    report();
  end
endmodule